// File: doc/BRIEF.md
# Two-Bank Scratchpad Memory with CPU and DMA Ports

This block is a 64 KB on-chip scratchpad split into two independent 32 KB halves. Each half is 2048 lines of 16 bytes. Two request ports, one for the processor and one for a DMA engine, reach the halves. When the two requests fall in different halves, both are served in the same clock cycle. When they fall in the same half, a small arbiter serves one port and holds the other off for exactly one cycle.

Addresses arrive as offsets within the 64 KB window. Matching the window against a base address happens outside the block. Each port does byte, 16-bit and 32-bit accesses. A granted read returns its data on the next cycle.

Top module: `dual_bank_sram`

## Requirements
- R1: Offset bit 15 selects the half (0 lower, 1 upper). Bits 14:4 select the line and bits 3:0 select the byte in the line. Byte k of a line lies at bits 8k+7:8k, so a multi-byte access is little-endian. The same line number in the two halves holds separate data.
- R2: The size code is 0 for a byte, 1 for 16 bits and 2 for 32 bits. A write stores the low 1, 2 or 4 bytes of wdata at addr and onward, and no other byte changes.
- R3: A read that is granted in cycle t shows its bytes on rdata in cycle t+1. The bytes are right-justified and the unused upper bits are zero. In every other cycle rdata is zero.
- R4: When both ports request and their half-select bits differ, both ready outputs are high in that cycle.
- R5: When both ports request the same half and the DMA port was not stalled in the previous cycle, CPU ready is high and DMA ready is low.
- R6: A DMA request that was stalled is granted in the next cycle. If the CPU still requests that same half in that cycle, CPU ready is low instead.
- R7: A port with no request shows ready high. An access with ready low changes no memory byte and returns no read data.
- R8: A CPU write and a DMA read to different halves in the same cycle both complete. The DMA read returns the contents as they stood before the write, and the CPU write is stored.
- R9: After reset, with no requests, both ready outputs are high, both rdata outputs are zero, and the DMA port has no pending priority.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | CPU access request |
| cpu_we | input | 1 | CPU write (1) or read (0) |
| cpu_size | input | 2 | CPU access size code |
| cpu_addr | input | 16 | CPU offset within the 64 KB window |
| cpu_wdata | input | 32 | CPU write data, right-justified |
| cpu_rdata | output | 32 | CPU read data, valid the cycle after a granted read |
| cpu_ready | output | 1 | CPU access accepted this cycle (or no request) |
| dma_req | input | 1 | DMA access request |
| dma_we | input | 1 | DMA write (1) or read (0) |
| dma_size | input | 2 | DMA access size code |
| dma_addr | input | 16 | DMA offset within the 64 KB window |
| dma_wdata | input | 32 | DMA write data, right-justified |
| dma_rdata | output | 32 | DMA read data, valid the cycle after a granted read |
| dma_ready | output | 1 | DMA access accepted this cycle (or no request) |

## Verification
The properties about readiness and arbitration make no assumption about the inputs. The one-cycle stall bound holds even when the DMA engine changes or drops a stalled request. The data requirements assume that every access is naturally aligned to its size and that size code 3 is never used. The random stimulus therefore draws only sizes 0 to 2 and masks each offset down to a multiple of the access width. When the DMA port is stalled, the stimulus also holds its request unchanged, as a real engine would.

// File: rtl/dbsram_pkg.sv
package dbsram_pkg;

    localparam int DATA_W     = 32;
    localparam int DATA_BYTES = DATA_W / 8;
    localparam int NUM_BANKS  = 2;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } size_e;

    // context of a read captured at grant time, used one cycle later
    typedef struct packed {
        logic  valid;
        logic  bank;
        size_e size;
    } rd_ctx_t;

    function automatic logic [DATA_BYTES-1:0] size_mask(size_e s);
        case (s)
            SZ_BYTE: size_mask = DATA_BYTES'(1);
            SZ_HALF: size_mask = DATA_BYTES'(3);
            default: size_mask = '1;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] bit_mask(size_e s);
        logic [DATA_BYTES-1:0] m;
        m = size_mask(s);
        for (int k = 0; k < DATA_BYTES; k++) begin
            bit_mask[8*k +: 8] = {8{m[k]}};
        end
    endfunction

endpackage

// File: rtl/sram_arbiter.sv
module sram_arbiter (
    input  logic clk,
    input  logic rst,
    input  logic cpu_req,
    input  logic cpu_bank,
    input  logic dma_req,
    input  logic dma_bank,
    output logic cpu_gnt,
    output logic dma_gnt
);

    logic clash;
    logic dma_owed;

    always_comb begin
        clash   = cpu_req && dma_req && (cpu_bank == dma_bank);
        cpu_gnt = cpu_req && !(clash && dma_owed);
        dma_gnt = dma_req && !(clash && !dma_owed);
    end

    // a DMA port that lost a clash wins the following one
    always_ff @(posedge clk) begin
        if (rst) begin
            dma_owed <= 1'b0;
        end else begin
            dma_owed <= clash && !dma_owed;
        end
    end

endmodule

// File: rtl/sram_bank.sv
module sram_bank #(
    parameter int LINES      = 2048,
    parameter int LINE_BYTES = 16,
    localparam int LINE_W    = $clog2(LINES),
    localparam int LINE_BITS = LINE_BYTES * 8
) (
    input  logic                  clk,
    input  logic                  en,
    input  logic                  we,
    input  logic [LINE_W-1:0]     line,
    input  logic [LINE_BYTES-1:0] ben,
    input  logic [LINE_BITS-1:0]  wline,
    output logic [LINE_BITS-1:0]  rline
);

    logic [LINE_BITS-1:0] mem [LINES];

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                for (int k = 0; k < LINE_BYTES; k++) begin
                    if (ben[k]) begin
                        mem[line][8*k +: 8] <= wline[8*k +: 8];
                    end
                end
            end else begin
                rline <= mem[line];
            end
        end
    end

endmodule

// File: rtl/sram_port_slice.sv
module sram_port_slice
    import dbsram_pkg::*;
#(
    parameter int LINES      = 2048,
    parameter int LINE_BYTES = 16,
    localparam int LINE_W    = $clog2(LINES),
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int ADDR_W    = 1 + LINE_W + OFF_W,
    localparam int LINE_BITS = LINE_BYTES * 8
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                gnt,
    input  logic                                we,
    input  logic [1:0]                          size,
    input  logic [ADDR_W-1:0]                   addr,
    input  logic [DATA_W-1:0]                   wdata,
    input  logic [NUM_BANKS-1:0][LINE_BITS-1:0] rlines,
    output logic                                bank,
    output logic [LINE_W-1:0]                   line,
    output logic [LINE_BYTES-1:0]               ben,
    output logic [LINE_BITS-1:0]                wline,
    output logic [DATA_W-1:0]                   rdata
);

    size_e             sz;
    logic [OFF_W-1:0]  off;
    rd_ctx_t           ctx_q;
    logic [OFF_W-1:0]  off_q;
    logic [LINE_BITS-1:0] sel_line;

    always_comb begin
        sz    = size_e'(size);
        off   = addr[OFF_W-1:0];
        bank  = addr[ADDR_W-1];
        line  = addr[ADDR_W-2:OFF_W];
        ben   = LINE_BYTES'(size_mask(sz)) << off;
        wline = LINE_BITS'(wdata) << {off, 3'b000};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx_q <= '0;
            off_q <= '0;
        end else begin
            ctx_q.valid <= gnt && !we;
            ctx_q.bank  <= bank;
            ctx_q.size  <= sz;
            off_q       <= off;
        end
    end

    always_comb begin
        sel_line = rlines[ctx_q.bank];
        if (ctx_q.valid) begin
            rdata = sel_line[{off_q, 3'b000} +: DATA_W] & bit_mask(ctx_q.size);
        end else begin
            rdata = '0;
        end
    end

endmodule

// File: rtl/dual_bank_sram.sv
module dual_bank_sram
    import dbsram_pkg::*;
#(
    parameter int LINES      = 2048,
    parameter int LINE_BYTES = 16,
    localparam int LINE_W    = $clog2(LINES),
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int ADDR_W    = 1 + LINE_W + OFF_W,
    localparam int LINE_BITS = LINE_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [1:0]        cpu_size,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    input  logic              dma_req,
    input  logic              dma_we,
    input  logic [1:0]        dma_size,
    input  logic [ADDR_W-1:0] dma_addr,
    input  logic [DATA_W-1:0] dma_wdata,
    output logic [DATA_W-1:0] dma_rdata,
    output logic              dma_ready
);

    logic cpu_gnt, dma_gnt;
    logic cpu_bank, dma_bank;
    logic [LINE_W-1:0]     cpu_line, dma_line;
    logic [LINE_BYTES-1:0] cpu_ben, dma_ben;
    logic [LINE_BITS-1:0]  cpu_wline, dma_wline;
    logic [NUM_BANKS-1:0][LINE_BITS-1:0] rlines;

    sram_arbiter u_arb (
        .clk      (clk),
        .rst      (rst),
        .cpu_req  (cpu_req),
        .cpu_bank (cpu_bank),
        .dma_req  (dma_req),
        .dma_bank (dma_bank),
        .cpu_gnt  (cpu_gnt),
        .dma_gnt  (dma_gnt)
    );

    sram_port_slice #(.LINES(LINES), .LINE_BYTES(LINE_BYTES)) u_cpu_port (
        .clk    (clk),
        .rst    (rst),
        .gnt    (cpu_gnt),
        .we     (cpu_we),
        .size   (cpu_size),
        .addr   (cpu_addr),
        .wdata  (cpu_wdata),
        .rlines (rlines),
        .bank   (cpu_bank),
        .line   (cpu_line),
        .ben    (cpu_ben),
        .wline  (cpu_wline),
        .rdata  (cpu_rdata)
    );

    sram_port_slice #(.LINES(LINES), .LINE_BYTES(LINE_BYTES)) u_dma_port (
        .clk    (clk),
        .rst    (rst),
        .gnt    (dma_gnt),
        .we     (dma_we),
        .size   (dma_size),
        .addr   (dma_addr),
        .wdata  (dma_wdata),
        .rlines (rlines),
        .bank   (dma_bank),
        .line   (dma_line),
        .ben    (dma_ben),
        .wline  (dma_wline),
        .rdata  (dma_rdata)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : gen_bank
        logic c_sel, d_sel;

        // the arbiter never grants both ports into one bank
        assign c_sel = cpu_gnt && (cpu_bank == 1'(b));
        assign d_sel = dma_gnt && (dma_bank == 1'(b));

        sram_bank #(.LINES(LINES), .LINE_BYTES(LINE_BYTES)) u_bank (
            .clk   (clk),
            .en    (c_sel || d_sel),
            .we    (d_sel ? dma_we    : cpu_we),
            .line  (d_sel ? dma_line  : cpu_line),
            .ben   (d_sel ? dma_ben   : cpu_ben),
            .wline (d_sel ? dma_wline : cpu_wline),
            .rline (rlines[b])
        );
    end

    assign cpu_ready = cpu_gnt || !cpu_req;
    assign dma_ready = dma_gnt || !dma_req;

endmodule

// File: rtl/dbsram_checker.sv
module dbsram_checker (
    input logic        clk,
    input logic        rst,
    input logic        cpu_req,
    input logic        cpu_we,
    input logic        cpu_bank,
    input logic        cpu_ready,
    input logic [31:0] cpu_rdata,
    input logic        dma_req,
    input logic        dma_bank,
    input logic        dma_ready
);

    // two ports never both accepted into one half
    p_no_double_grant_r5: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && cpu_ready && dma_req && dma_ready) |-> (cpu_bank != dma_bank));

    p_split_both_ready_r4: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && dma_req && (cpu_bank != dma_bank)) |-> (cpu_ready && dma_ready));

    p_fresh_clash_cpu_wins_r5: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && dma_req && (cpu_bank == dma_bank) && $past(dma_ready))
        |-> (cpu_ready && !dma_ready));

    p_dma_stall_one_cycle_r6: assert property (@(posedge clk) disable iff (rst)
        (dma_req && !dma_ready) |=> dma_ready);

    p_cpu_stall_after_dma_stall_r6: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && !cpu_ready) |-> $past(dma_req && !dma_ready));

    p_idle_ready_r7: assert property (@(posedge clk) disable iff (rst)
        ((!cpu_req -> cpu_ready) && (!dma_req -> dma_ready)));

    p_idle_rdata_zero_r3: assert property (@(posedge clk) disable iff (rst)
        !$past(cpu_req && cpu_ready && !cpu_we) |-> (cpu_rdata == 32'h0));

endmodule

bind dual_bank_sram dbsram_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .cpu_req   (cpu_req),
    .cpu_we    (cpu_we),
    .cpu_bank  (cpu_addr[ADDR_W-1]),
    .cpu_ready (cpu_ready),
    .cpu_rdata (cpu_rdata),
    .dma_req   (dma_req),
    .dma_bank  (dma_addr[ADDR_W-1]),
    .dma_ready (dma_ready)
);

// File: tb/dual_bank_sram_tb.sv
`timescale 1ns/1ps
module dual_bank_sram_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req = 0, cpu_we = 0;
    logic [1:0]  cpu_size = 0;
    logic [15:0] cpu_addr = 0;
    logic [31:0] cpu_wdata = 0;
    logic [31:0] cpu_rdata;
    logic        cpu_ready;
    logic        dma_req = 0, dma_we = 0;
    logic [1:0]  dma_size = 0;
    logic [15:0] dma_addr = 0;
    logic [31:0] dma_wdata = 0;
    logic [31:0] dma_rdata;
    logic        dma_ready;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;
    bit owed_m = 0;
    logic [7:0] ref_mem [int];

    always #10 clk = ~clk;

    dual_bank_sram dut_i (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_size(cpu_size), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .dma_req(dma_req), .dma_we(dma_we), .dma_size(dma_size), .dma_addr(dma_addr),
        .dma_wdata(dma_wdata), .dma_rdata(dma_rdata), .dma_ready(dma_ready)
    );

    function automatic int nbytes(logic [1:0] s);
        return (s == 2'd0) ? 1 : ((s == 2'd1) ? 2 : 4);
    endfunction

    function automatic logic [31:0] exp_read(logic [15:0] a, logic [1:0] s);
        logic [31:0] v = '0;
        for (int i = 0; i < nbytes(s); i++) begin
            v[8*i +: 8] = ref_mem.exists(int'(a) + i) ? ref_mem[int'(a) + i] : 8'h00;
        end
        return v;
    endfunction

    task automatic write_ref(logic [15:0] a, logic [1:0] s, logic [31:0] d);
        for (int i = 0; i < nbytes(s); i++) begin
            ref_mem[int'(a) + i] = d[8*i +: 8];
        end
    endtask

    task automatic chk(logic [31:0] act, logic [31:0] exp, string tag, string what);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // drives one cycle starting at a falling edge; ends at the next falling edge
    task automatic do_cycle(
        input logic cr, input logic cw, input logic [1:0] cs, input logic [15:0] ca, input logic [31:0] cd,
        input logic dr, input logic dw, input logic [1:0] ds, input logic [15:0] da, input logic [31:0] dd,
        input string rtag, output logic dstalled);
        logic clash, ecg, edg;
        logic [31:0] ecr, edr;
        string tag;
        cpu_req = cr; cpu_we = cw; cpu_size = cs; cpu_addr = ca; cpu_wdata = cd;
        dma_req = dr; dma_we = dw; dma_size = ds; dma_addr = da; dma_wdata = dd;
        #1;
        clash = cr && dr && (ca[15] == da[15]);
        ecg = cr && !(clash && owed_m);
        edg = dr && !(clash && !owed_m);
        tag = clash ? (owed_m ? "R6" : "R5") : ((cr && dr) ? "R4" : "R7");
        chk(32'(cpu_ready), 32'(ecg || !cr), tag, "cpu_ready");
        chk(32'(dma_ready), 32'(edg || !dr), tag, "dma_ready");
        ecr = (ecg && !cw) ? exp_read(ca, cs) : 32'h0;
        edr = (edg && !dw) ? exp_read(da, ds) : 32'h0;
        if (ecg && cw) write_ref(ca, cs, cd);
        if (edg && dw) write_ref(da, ds, dd);
        owed_m = clash && !owed_m;
        dstalled = dr && !edg;
        @(posedge clk);
        @(negedge clk);
        chk(cpu_rdata, ecr, rtag, "cpu_rdata");
        chk(dma_rdata, edr, rtag, "dma_rdata");
    endtask

    task automatic idle_cycle();
        logic s;
        do_cycle(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R7", s);
    endtask

    function automatic logic [15:0] rand_addr(logic [1:0] s);
        logic [10:0] pool [4] = '{11'd0, 11'd5, 11'd1234, 11'd2047};
        logic [3:0] off;
        off = 4'($urandom % 16);
        off = off & ~4'(nbytes(s) - 1);
        return {1'($urandom % 2), pool[$urandom % 4], off};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        logic st;
        logic pend;
        logic dr, dw;
        logic [1:0] ds;
        logic [15:0] da;
        logic [31:0] dd;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R9: state right after reset
        chk(32'(cpu_ready), 32'd1, "R9", "cpu_ready after reset");
        chk(32'(dma_ready), 32'd1, "R9", "dma_ready after reset");
        chk(cpu_rdata, 32'h0, "R9", "cpu_rdata after reset");
        chk(dma_rdata, 32'h0, "R9", "dma_rdata after reset");
        @(negedge clk);

        // R1: same line number in both halves keeps separate data (concurrent, R4)
        do_cycle(1, 1, 2, 16'h0010, 32'hA5A5_0001, 1, 1, 2, 16'h8010, 32'h5A5A_0002, "R1", st);
        do_cycle(1, 0, 2, 16'h0010, 0, 1, 0, 2, 16'h8010, 0, "R1", st);
        do_cycle(1, 1, 2, 16'h0040, 32'h1111_2222, 0, 0, 0, 0, 0, "R1", st);

        // R2: byte and halfword writes touch only their bytes
        do_cycle(1, 1, 0, 16'h0013, 32'hFFFF_FF77, 0, 0, 0, 0, 0, "R2", st);
        do_cycle(0, 0, 0, 0, 0, 1, 1, 1, 16'h8012, 32'hFFFF_BEEF, "R2", st);
        do_cycle(1, 0, 2, 16'h0010, 0, 1, 0, 2, 16'h8010, 0, "R2", st);
        do_cycle(1, 0, 0, 16'h0013, 0, 1, 0, 1, 16'h8012, 0, "R2", st);

        // R8: CPU write and DMA read in different halves, same cycle
        do_cycle(1, 1, 2, 16'h8010, 32'hCAFE_F00D, 1, 0, 2, 16'h0010, 0, "R8", st);
        do_cycle(1, 0, 2, 16'h8010, 0, 1, 0, 2, 16'h0010, 0, "R8", st);

        // R5 then R6: repeated clash in the lower half
        do_cycle(1, 0, 2, 16'h0010, 0, 1, 0, 2, 16'h0040, 0, "R5", st);
        chk(32'(st), 32'd1, "R5", "dma stalled on fresh clash");
        do_cycle(1, 0, 2, 16'h0010, 0, 1, 0, 2, 16'h0040, 0, "R6", st);
        chk(32'(st), 32'd0, "R6", "dma served after one stall");
        do_cycle(1, 0, 2, 16'h0010, 0, 1, 0, 2, 16'h0040, 0, "R5", st);

        // R7: a stalled DMA write that is then withdrawn leaves memory unchanged
        idle_cycle();
        do_cycle(1, 0, 2, 16'h0010, 0, 1, 1, 2, 16'h0040, 32'hDEAD_DEAD, "R7", st);
        do_cycle(1, 0, 2, 16'h0040, 0, 0, 0, 0, 0, 0, "R7", st);
        chk(32'(owed_m), 32'd0, "R7", "model priority cleared");

        // pool preload for random phase
        for (int b = 0; b < 2; b++) begin
            for (int l = 0; l < 4; l++) begin
                for (int w = 0; w < 4; w++) begin
                    logic [10:0] ln;
                    ln = (l == 0) ? 11'd0 : (l == 1) ? 11'd5 : (l == 2) ? 11'd1234 : 11'd2047;
                    do_cycle(1, 1, 2, {1'(b), ln, 4'(w * 4)}, $urandom, 0, 0, 0, 0, 0, "R3", st);
                end
            end
        end

        // random mix; a stalled DMA request is held
        pend = 0; dr = 0; dw = 0; ds = 0; da = 0; dd = 0;
        for (int i = 0; i < 600; i++) begin
            logic cr, cw;
            logic [1:0] cs;
            logic [15:0] ca;
            if (!pend) begin
                dr = ($urandom % 4) != 0;
                dw = 1'($urandom % 2);
                ds = 2'($urandom % 3);
                da = rand_addr(ds);
                dd = $urandom;
            end
            cr = ($urandom % 4) != 0;
            cw = 1'($urandom % 2);
            cs = 2'($urandom % 3);
            ca = rand_addr(cs);
            do_cycle(cr, cw, cs, ca, $urandom, dr, dw, ds, da, dd, "R3", pend);
        end

        idle_cycle();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule